// File: doc/BRIEF.md
# Accumulator Shift Execution Unit

This unit carries out the arithmetic shift instructions of a small 8-bit processor core. It receives an opcode byte and a flag that tells whether the opcode came after the stack-relative prefix byte. From these it works out the shift direction, where the operand comes from (the accumulator, the index register or a memory byte on a read-data input), and where the result goes. It also works out how many bus cycles the instruction takes. It produces the shifted byte, the carry, and the negative, zero and overflow flags.

When `start_i` is high in a cycle where the unit is idle and the opcode is a supported one, the unit accepts the instruction. It samples the operand at that clock edge and registers the result, flags, write-back target and cycle count. It stays busy for exactly the cycle count of the addressing mode. It raises `done_o` for one cycle in the last of those cycles. The registered outputs hold their values until the next instruction is accepted. The core uses `done_o` to commit the result to the target that `wb_sel_o` selects. Address generation and the rest of the condition-code register belong to other blocks.

Top module: `shift_exec_unit`

## Requirements
- R1: A left shift gives `result = operand << 1` with bit 0 cleared, and `carry_o` takes operand bit 7.
- R2: A right shift keeps bit 7, moves bits 7..1 down one place, and `carry_o` takes operand bit 0.
- R3: `zero_o` is 1 exactly when the result is 0x00, and `neg_o` equals result bit 7.
- R4: `ovf_o` equals `neg_o` XOR `carry_o` of the same instruction.
- R5: With `prefix_i`=0, opcode 0x47 right-shifts `acc_i` and opcode 0x57 right-shifts `idx_i`. Both take 1 cycle, with `wb_sel_o` = 2'b01 (accumulator) or 2'b10 (index register) respectively.
- R6: With `prefix_i`=0, opcode 0x78 left-shifts and opcode 0x77 right-shifts `mem_i`. Both take 4 cycles, with `wb_sel_o` = 2'b11 (memory).
- R7: With `prefix_i`=0, opcode 0x68 left-shifts and opcode 0x67 right-shifts `mem_i`. Both take 5 cycles, with `wb_sel_o` = 2'b11.
- R8: With `prefix_i`=1, opcode 0x68 left-shifts and opcode 0x67 right-shifts `mem_i`. Both take 6 cycles, with `wb_sel_o` = 2'b11.
- R9: With `prefix_i`=0, opcode 0x37 right-shifts `mem_i`. It takes 5 cycles, with `wb_sel_o` = 2'b11.
- R10: Out of reset, all outputs are 0. After an accepting edge, `busy_o` is high for exactly N cycles, where N is the value shown on `cycles_o`. `done_o` is high only in the N-th of those cycles, and is one cycle wide.
- R11: `start_i` is ignored while `busy_o` is high, including the `done_o` cycle. It changes neither the outputs nor the timing of the running instruction.
- R12: Any other opcode/prefix combination is ignored when started. `busy_o` stays low and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an instruction |
| opcode_i | input | 8 | Opcode byte |
| prefix_i | input | 1 | Opcode followed the stack-relative prefix byte |
| acc_i | input | 8 | Accumulator value |
| idx_i | input | 8 | Index register value |
| mem_i | input | 8 | Memory read data |
| result_o | output | 8 | Shifted byte |
| carry_o | output | 1 | New carry |
| neg_o | output | 1 | New negative flag |
| zero_o | output | 1 | New zero flag |
| ovf_o | output | 1 | New overflow flag |
| wb_sel_o | output | 2 | Write-back target: 00 none, 01 accumulator, 10 index, 11 memory |
| cycles_o | output | 3 | Bus cycle count of the accepted instruction |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start request that lands on the very cycle `done_o` is high. In that cycle the unit looks almost idle, and a careless design would accept the request a cycle early. The bench holds `start_i` high across whole instructions and also runs a long stream of random start, opcode and prefix values. This puts requests on every phase of every latency, including the completion cycle. A behavioural model checks every cycle that the timing and the registered outputs are left untouched.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    WB_NONE = 2'b00,
    WB_ACC  = 2'b01,
    WB_IDX  = 2'b10,
    WB_MEM  = 2'b11
  } wb_sel_e;

  localparam logic [7:0] OP_ASR_ACC = 8'h47;
  localparam logic [7:0] OP_ASR_IDX = 8'h57;
  localparam logic [7:0] OP_ASL_IX  = 8'h78;
  localparam logic [7:0] OP_ASR_IX  = 8'h77;
  localparam logic [7:0] OP_ASL_OFS = 8'h68;
  localparam logic [7:0] OP_ASR_OFS = 8'h67;
  localparam logic [7:0] OP_ASR_DIR = 8'h37;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int CYC_W   = 3,
  parameter int LAT_INH = 1,
  parameter int LAT_IX  = 4,
  parameter int LAT_OFS = 5,
  parameter int LAT_SPR = 6,
  parameter int LAT_DIR = 5
) (
  input  logic [7:0]       opcode_i,
  input  logic             prefix_i,
  output logic             legal_o,
  output logic             left_o,
  output wb_sel_e          tgt_o,
  output logic [CYC_W-1:0] cycles_o
);
  always_comb begin
    legal_o  = 1'b1;
    left_o   = 1'b0;
    tgt_o    = WB_MEM;
    cycles_o = '0;
    if (prefix_i) begin
      unique case (opcode_i)
        OP_ASL_OFS: begin left_o = 1'b1; cycles_o = CYC_W'(LAT_SPR); end
        OP_ASR_OFS: cycles_o = CYC_W'(LAT_SPR);
        default: begin legal_o = 1'b0; tgt_o = WB_NONE; end
      endcase
    end else begin
      unique case (opcode_i)
        OP_ASR_ACC: begin tgt_o = WB_ACC; cycles_o = CYC_W'(LAT_INH); end
        OP_ASR_IDX: begin tgt_o = WB_IDX; cycles_o = CYC_W'(LAT_INH); end
        OP_ASL_IX:  begin left_o = 1'b1; cycles_o = CYC_W'(LAT_IX); end
        OP_ASR_IX:  cycles_o = CYC_W'(LAT_IX);
        OP_ASL_OFS: begin left_o = 1'b1; cycles_o = CYC_W'(LAT_OFS); end
        OP_ASR_OFS: cycles_o = CYC_W'(LAT_OFS);
        OP_ASR_DIR: cycles_o = CYC_W'(LAT_DIR);
        default: begin legal_o = 1'b0; tgt_o = WB_NONE; end
      endcase
    end
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (left_i) begin
      result_o = {operand_i[MSB-1:0], 1'b0};
      carry_o  = operand_i[MSB];
    end else begin
      result_o = {operand_i[MSB], operand_i[MSB:1]};
      carry_o  = operand_i[0];
    end
    neg_o  = result_o[MSB];
    zero_o = ~|result_o;
    ovf_o  = neg_o ^ carry_o;
  end
endmodule

// File: rtl/shift_seq.sv
module shift_seq #(
  parameter int CYC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             legal_i,
  input  logic [CYC_W-1:0] cycles_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CYC_W-1:0] cnt_q;

  assign accept_o = start_i && legal_i && (cnt_q == '0);
  assign busy_o   = (cnt_q != '0);
  assign done_o   = (cnt_q == CYC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (accept_o) cnt_q <= cycles_i;
    else if (busy_o)   cnt_q <= cnt_q - CYC_W'(1);
  end

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && (cnt_q == $past(cycles_i)));
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LAT_INH = 1,
  parameter int LAT_IX  = 4,
  parameter int LAT_OFS = 5,
  parameter int LAT_SPR = 6,
  parameter int LAT_DIR = 5,
  localparam int LAT_MAX = (LAT_SPR > LAT_OFS) ? LAT_SPR : LAT_OFS,
  localparam int CYC_W   = $clog2(LAT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic              prefix_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic [1:0]        wb_sel_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MSB = DATA_W - 1;

  logic             legal, left, accept;
  wb_sel_e          tgt;
  logic [CYC_W-1:0] dec_cycles;
  logic [DATA_W-1:0] operand, alu_res;
  logic             alu_c, alu_n, alu_z, alu_v;

  shift_decode #(
    .CYC_W(CYC_W), .LAT_INH(LAT_INH), .LAT_IX(LAT_IX),
    .LAT_OFS(LAT_OFS), .LAT_SPR(LAT_SPR), .LAT_DIR(LAT_DIR)
  ) u_decode (
    .opcode_i (opcode_i),
    .prefix_i (prefix_i),
    .legal_o  (legal),
    .left_o   (left),
    .tgt_o    (tgt),
    .cycles_o (dec_cycles)
  );

  // operand source follows write-back target
  always_comb begin
    unique case (tgt)
      WB_ACC:  operand = acc_i;
      WB_IDX:  operand = idx_i;
      default: operand = mem_i;
    endcase
  end

  shift_alu #(.DATA_W(DATA_W)) u_alu (
    .operand_i (operand),
    .left_i    (left),
    .result_o  (alu_res),
    .carry_o   (alu_c),
    .neg_o     (alu_n),
    .zero_o    (alu_z),
    .ovf_o     (alu_v)
  );

  shift_seq #(.CYC_W(CYC_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .legal_i  (legal),
    .cycles_i (dec_cycles),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      wb_sel_o <= WB_NONE;
      cycles_o <= '0;
    end else if (accept) begin
      result_o <= alu_res;
      carry_o  <= alu_c;
      neg_o    <= alu_n;
      zero_o   <= alu_z;
      ovf_o    <= alu_v;
      wb_sel_o <= tgt;
      cycles_o <= dec_cycles;
    end
  end

  p_asl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && left) |=> (result_o[0] == 1'b0) && (carry_o == $past(operand[MSB])));
  p_asr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !left) |=> (result_o[MSB] == $past(operand[MSB])) && (carry_o == $past(operand[0])));
  p_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (zero_o == (result_o == '0)) && (neg_o == result_o[MSB]));
  p_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ovf_o == (neg_o ^ carry_o)));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(result_o) && $stable(wb_sel_o) && $stable(cycles_o));
  p_illegal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !legal) |=> !busy_o && $stable(result_o));
endmodule

// File: tb/shift_exec_unit_tb.sv
`timescale 1ns/1ps
module shift_exec_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic       prefix_i = 1'b0;
  logic [7:0] acc_i = 8'h00, idx_i = 8'h00, mem_i = 8'h00;
  logic [7:0] result_o;
  logic       carry_o, neg_o, zero_o, ovf_o, busy_o, done_o;
  logic [1:0] wb_sel_o;
  logic [2:0] cycles_o;

  shift_exec_unit u_dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  string phase = "R10";

  // reference model state
  int m_cnt = 0, m_res = 0, m_c = 0, m_n = 0, m_z = 0, m_v = 0, m_wb = 0, m_cyc = 0;
  string t_shift = "R1", t_mode = "R10";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // decode per requirement tables: returns latency 0 when unsupported
  function automatic int lat_of(input logic [7:0] op, input logic pre);
    if (pre) return (op == 8'h68 || op == 8'h67) ? 6 : 0;
    case (op)
      8'h47, 8'h57: return 1;
      8'h78, 8'h77: return 4;
      8'h68, 8'h67, 8'h37: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic string mode_tag(input logic [7:0] op, input logic pre);
    if (pre) return "R8";
    case (op)
      8'h47, 8'h57: return "R5";
      8'h78, 8'h77: return "R6";
      8'h37: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    chk(busy_o === (m_cnt != 0), phase, "busy_o", busy_o, m_cnt != 0);
    chk(done_o === (m_cnt == 1), phase, "done_o", done_o, m_cnt == 1);
    chk(result_o === m_res[7:0], t_shift, "result_o", result_o, m_res);
    chk(carry_o === m_c[0], t_shift, "carry_o", carry_o, m_c);
    chk(zero_o === m_z[0], "R3", "zero_o", zero_o, m_z);
    chk(neg_o === m_n[0], "R3", "neg_o", neg_o, m_n);
    chk(ovf_o === m_v[0], "R4", "ovf_o", ovf_o, m_v);
    chk(wb_sel_o === m_wb[1:0], t_mode, "wb_sel_o", wb_sel_o, m_wb);
    chk(cycles_o === m_cyc[2:0], t_mode, "cycles_o", cycles_o, m_cyc);
  endtask

  // one clock: check outputs, drive inputs, advance model across next edge
  task automatic cyc(input bit s, input logic [7:0] op, input bit pre,
                     input logic [7:0] a, input logic [7:0] x, input logic [7:0] m);
    int lat, v;
    @(negedge clk_i);
    compare();
    start_i = s; opcode_i = op; prefix_i = pre; acc_i = a; idx_i = x; mem_i = m;
    lat = lat_of(op, pre);
    if (m_cnt == 0 && s && lat != 0) begin
      m_cyc = lat;
      t_mode = mode_tag(op, pre);
      if (!pre && op == 8'h47) begin v = a; m_wb = 1; end
      else if (!pre && op == 8'h57) begin v = x; m_wb = 2; end
      else begin v = m; m_wb = 3; end
      if (op == 8'h78 || op == 8'h68) begin
        t_shift = "R1";
        m_res = (v * 2) % 256;
        m_c = (v >= 128) ? 1 : 0;
      end else begin
        t_shift = "R2";
        m_res = (v / 2) + ((v >= 128) ? 128 : 0);
        m_c = v % 2;
      end
      m_z = (m_res == 0) ? 1 : 0;
      m_n = (m_res >= 128) ? 1 : 0;
      m_v = (m_n != m_c) ? 1 : 0;
      m_cnt = lat;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end
  endtask

  task automatic run(input logic [7:0] op, input bit pre, input logic [7:0] a,
                     input logic [7:0] x, input logic [7:0] m, input bit hold_start);
    cyc(1'b1, op, pre, a, x, m);
    while (m_cnt != 0) cyc(hold_start, hold_start ? 8'h47 : op, pre, ~a, ~x, ~m);
    cyc(1'b0, op, pre, a, x, m);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset state checked by first compare
    phase = "R10";
    cyc(0, 8'h00, 0, 8'h00, 8'h00, 8'h00);
    run(8'h47, 0, 8'h81, 8'h11, 8'h22, 0);   // R5 R2: 81 -> C0 C=1
    run(8'h57, 0, 8'h33, 8'h01, 8'h44, 0);   // R5 R3: 01 -> 00 Z=1 V=1
    run(8'h78, 0, 8'h01, 8'h02, 8'h80, 0);   // R6 R1: 80 -> 00 C=1
    run(8'h77, 0, 8'h01, 8'h02, 8'h7E, 0);   // R6 R2: 7E -> 3F
    run(8'h68, 0, 8'h00, 8'h00, 8'h55, 0);   // R7 R1 R4: 55 -> AA V=1
    run(8'h67, 0, 8'h00, 8'h00, 8'hFF, 0);   // R7 R2
    run(8'h68, 1, 8'h00, 8'h00, 8'hC3, 0);   // R8 R1
    run(8'h67, 1, 8'h00, 8'h00, 8'h02, 0);   // R8 R2
    run(8'h37, 0, 8'h00, 8'h00, 8'h9A, 0);   // R9 R2
    phase = "R11";
    run(8'h67, 1, 8'h12, 8'h34, 8'h56, 1);   // start held through busy and done
    run(8'h78, 0, 8'h12, 8'h34, 8'h40, 1);
    phase = "R12";
    run(8'h48, 0, 8'hFF, 8'hFF, 8'hFF, 0);   // unsupported
    run(8'h47, 1, 8'hFF, 8'hFF, 8'hFF, 0);   // prefix on inherent form
    run(8'h37, 1, 8'hFF, 8'hFF, 8'hFF, 0);
    run(8'h9E, 0, 8'hFF, 8'hFF, 8'hFF, 0);
    phase = "R11";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ops [8] = '{8'h47, 8'h57, 8'h78, 8'h77, 8'h68, 8'h67, 8'h37, 8'h58};
      cyc(1'($urandom), ops[$urandom % 8], 1'(($urandom % 4) == 0),
          8'($urandom), 8'($urandom), 8'($urandom));
    end
    cyc(0, 8'h00, 0, 8'h00, 8'h00, 8'h00);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule